// File: doc/BRIEF.md
# Block Copy and Fill Sequencer

This engine turns a single trigger into a fixed 32-byte transfer on a simple memory master port. A trigger carries a space code, an address and two 32-bit operands. With the copy space code, the first operand is read as a source address and the trigger address as the destination. The engine then moves the block as eight word reads, each followed by a write of the word it just read. With the fill space code, the two operands are joined into a 64-bit pattern, and the engine writes that pattern four times, as doublewords, from the trigger address.

The engine takes at most one trigger at a time. `busy` is high while a transfer is in progress, and `trig_ready` is low over the same interval, so a trigger that arrives during a transfer waits. Every memory beat holds its request stable until `mem_ready` completes the handshake. Trigger codes other than the two recognised ones are accepted and then dropped.

Top module: `blkmov_engine`

## Requirements
- R1: After reset, `busy` and `mem_valid` are low and `trig_ready` is high.
- R2: A trigger accepted with space code 0x17 starts a copy. The source is `trig_data_hi` with bits 1:0 cleared, and the destination is `trig_addr` with bits 1:0 cleared.
- R3: A copy makes sixteen beats, all with `mem_size` 2 (4 bytes). Reads (`mem_write`=0) at source+4*i alternate with writes (`mem_write`=1) at destination+4*i, for i from 0 to 7. Each write carries the word just read in `mem_wdata[31:0]`, with zeros in bits 63:32.
- R4: A trigger accepted with space code 0x1F starts a fill. It makes four writes with `mem_size` 3 (8 bytes) at (`trig_addr` with bits 2:0 cleared)+8*i, each with `mem_wdata` = {`trig_data_hi`, `trig_data_lo`}.
- R5: While `mem_valid` is high and `mem_ready` is low, the engine holds the beat: `mem_valid`, `mem_addr`, `mem_write` and `mem_size` do not change, and it does not advance.
- R6: `busy` is high in the cycle after a copy or fill trigger is accepted. It goes low in the cycle after the last write is accepted. `trig_ready` is the inverse of `busy`, so triggers are held back while a transfer runs.
- R7: A trigger accepted with any other space code has no effect: `busy` stays low and no memory beat is issued.
- R8: `mem_valid` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger request |
| trig_ready | output | 1 | Trigger can be accepted (engine idle) |
| trig_space | input | 8 | Space code selecting copy, fill or nothing |
| trig_addr | input | 32 | Trigger address (destination) |
| trig_data_hi | input | 32 | First operand: copy source or upper fill half |
| trig_data_lo | input | 32 | Second operand: lower fill half |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory beat accepted |
| mem_write | output | 1 | 1 for write, 0 for read |
| mem_size | output | 2 | Log2 of the beat size in bytes |
| mem_addr | output | 32 | Beat address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 32 | Read data, valid when a read beat is accepted |
| busy | output | 1 | Transfer in progress |

## Verification
A sequencer state that skips or repeats a step appears on the port at the next beat. It shows as two reads or two writes in a row, or as a beat whose address is 4 away from the expected one. The bench logs every accepted beat and compares the log with the beat list derived from the trigger. A miscounted beat counter changes the number of logged beats and moves the falling edge of `busy`, which is checked in the exact cycle after the last write. A write-data register that captured the wrong value shows on the very next write beat.

// File: rtl/blkmov_pkg.sv
package blkmov_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WRITE = 2'd2,
    ST_FILL = 2'd3
  } blkmov_state_e;
endpackage

// File: rtl/blkmov_trig_decode.sv
module blkmov_trig_decode #(
  parameter int          SPACE_W    = 8,
  parameter logic [7:0]  COPY_SPACE = 8'h17,
  parameter logic [7:0]  FILL_SPACE = 8'h1F
) (
  input  logic               accept,
  input  logic [SPACE_W-1:0] space,
  output logic               start_copy,
  output logic               start_fill
);
  assign start_copy = accept && (space == SPACE_W'(COPY_SPACE));
  assign start_fill = accept && (space == SPACE_W'(FILL_SPACE));
endmodule

// File: rtl/blkmov_beat_count.sv
module blkmov_beat_count #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  input  logic [CNT_W-1:0] last_val,
  output logic             at_last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (inc)        cnt_q <= cnt_q + 1'b1;
  end

  assign at_last = (cnt_q == last_val);
endmodule

// File: rtl/blkmov_seq.sv
module blkmov_seq
  import blkmov_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_copy,
  input  logic                start_fill,
  input  logic [ADDR_W-1:0]   dst_in,
  input  logic [WORD_W-1:0]   op_hi,
  input  logic [WORD_W-1:0]   op_lo,
  input  logic                beat_done,
  input  logic                last_beat,
  input  logic [WORD_W-1:0]   rdata,
  output logic                mem_valid,
  output logic                mem_write,
  output logic [1:0]          mem_size,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [2*WORD_W-1:0] mem_wdata,
  output logic                fill_mode,
  output logic                busy
);
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int LG_WORD    = $clog2(WORD_BYTES);
  localparam int LG_DWORD   = LG_WORD + 1;
  localparam logic [1:0] SZ_WORD  = 2'(LG_WORD);
  localparam logic [1:0] SZ_DWORD = 2'(LG_DWORD);

  function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a,
                                                   input int lg);
    return a & ~((ADDR_W'(1) << lg) - ADDR_W'(1));
  endfunction

  function automatic logic [ADDR_W-1:0] step_up(input logic [ADDR_W-1:0] a,
                                                input int lg);
    return a + (ADDR_W'(1) << lg);
  endfunction

  blkmov_state_e       state_q;
  logic [ADDR_W-1:0]   src_q, dst_q;
  logic [2*WORD_W-1:0] pat_q;
  logic [WORD_W-1:0]   held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      pat_q   <= '0;
      held_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_copy) begin
            src_q   <= align_down(ADDR_W'(op_hi), LG_WORD);
            dst_q   <= align_down(dst_in, LG_WORD);
            state_q <= ST_READ;
          end else if (start_fill) begin
            dst_q   <= align_down(dst_in, LG_DWORD);
            pat_q   <= {op_hi, op_lo};
            state_q <= ST_FILL;
          end
        end
        ST_READ: begin
          if (beat_done) begin
            held_q  <= rdata;
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (beat_done) begin
            src_q   <= step_up(src_q, LG_WORD);
            dst_q   <= step_up(dst_q, LG_WORD);
            state_q <= last_beat ? ST_IDLE : ST_READ;
          end
        end
        ST_FILL: begin
          if (beat_done) begin
            dst_q <= step_up(dst_q, LG_DWORD);
            if (last_beat) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign mem_valid = busy;
  assign mem_write = (state_q == ST_WRITE) || (state_q == ST_FILL);
  assign fill_mode = (state_q == ST_FILL);
  assign mem_size  = fill_mode ? SZ_DWORD : SZ_WORD;
  assign mem_addr  = (state_q == ST_READ) ? src_q : dst_q;
  assign mem_wdata = fill_mode ? pat_q : {{WORD_W{1'b0}}, held_q};
endmodule

// File: rtl/blkmov_engine.sv
module blkmov_engine #(
  parameter int         ADDR_W      = 32,
  parameter int         WORD_W      = 32,
  parameter int         SPACE_W     = 8,
  parameter int         BLOCK_BYTES = 32,
  parameter logic [7:0] COPY_SPACE  = 8'h17,
  parameter logic [7:0] FILL_SPACE  = 8'h1F
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig_valid,
  output logic                trig_ready,
  input  logic [SPACE_W-1:0]  trig_space,
  input  logic [ADDR_W-1:0]   trig_addr,
  input  logic [WORD_W-1:0]   trig_data_hi,
  input  logic [WORD_W-1:0]   trig_data_lo,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic                mem_write,
  output logic [1:0]          mem_size,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [2*WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic                busy
);
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int COPY_BEATS = BLOCK_BYTES / WORD_BYTES;
  localparam int FILL_BEATS = BLOCK_BYTES / (2 * WORD_BYTES);
  localparam int CNT_W      = $clog2(COPY_BEATS + 1);

  logic accept, start_copy, start_fill;
  logic beat_done, write_done, last_beat, fill_mode;
  logic [CNT_W-1:0] last_val;

  assign trig_ready = !busy;
  assign accept     = trig_valid && trig_ready;
  assign beat_done  = mem_valid && mem_ready;
  assign write_done = beat_done && mem_write;
  assign last_val   = fill_mode ? CNT_W'(FILL_BEATS - 1) : CNT_W'(COPY_BEATS - 1);

  blkmov_trig_decode #(
    .SPACE_W(SPACE_W), .COPY_SPACE(COPY_SPACE), .FILL_SPACE(FILL_SPACE)
  ) i_decode (
    .accept(accept), .space(trig_space),
    .start_copy(start_copy), .start_fill(start_fill)
  );

  blkmov_beat_count #(.CNT_W(CNT_W)) i_count (
    .clk(clk), .rst_n(rst_n), .clear(accept), .inc(write_done),
    .last_val(last_val), .at_last(last_beat)
  );

  blkmov_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_seq (
    .clk(clk), .rst_n(rst_n),
    .start_copy(start_copy), .start_fill(start_fill),
    .dst_in(trig_addr), .op_hi(trig_data_hi), .op_lo(trig_data_lo),
    .beat_done(beat_done), .last_beat(last_beat), .rdata(mem_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .fill_mode(fill_mode), .busy(busy)
  );
endmodule

// File: rtl/blkmov_checker.sv
module blkmov_checker #(
  parameter int         ADDR_W     = 32,
  parameter int         SPACE_W    = 8,
  parameter logic [7:0] COPY_SPACE = 8'h17,
  parameter logic [7:0] FILL_SPACE = 8'h1F
) (
  input logic               clk,
  input logic               rst_n,
  input logic               trig_ready,
  input logic               accept,
  input logic [SPACE_W-1:0] trig_space,
  input logic               mem_valid,
  input logic               mem_ready,
  input logic               mem_write,
  input logic [1:0]         mem_size,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic               beat_done,
  input logic               busy
);
  logic op_code, other_code;
  assign op_code    = (trig_space == SPACE_W'(COPY_SPACE)) || (trig_space == SPACE_W'(FILL_SPACE));
  assign other_code = !op_code;

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !busy && !mem_valid && trig_ready);

  a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done && !mem_write |=> mem_valid && mem_write && mem_size == 2'd2);

  a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_size == 2'd2 |-> mem_addr[1:0] == 2'b00);

  a_r4_fill_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_size == 2'd3 |-> mem_write && mem_addr[2:0] == 3'b000);

  a_r5_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write)
                                && $stable(mem_size));

  a_r6_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_code |=> busy);

  a_r6_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !trig_ready);

  a_r7_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    accept && other_code |=> !busy && !mem_valid);

  a_r8_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy);
endmodule

bind blkmov_engine blkmov_checker #(
  .ADDR_W(ADDR_W), .SPACE_W(SPACE_W), .COPY_SPACE(COPY_SPACE), .FILL_SPACE(FILL_SPACE)
) i_blkmov_checker (
  .clk(clk), .rst_n(rst_n), .trig_ready(trig_ready), .accept(accept),
  .trig_space(trig_space), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_write(mem_write), .mem_size(mem_size), .mem_addr(mem_addr),
  .beat_done(beat_done), .busy(busy)
);

// File: tb/test_blkmov_engine.sv
module test_blkmov_engine;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        trig_valid = 1'b0;
  logic        trig_ready;
  logic [7:0]  trig_space = '0;
  logic [31:0] trig_addr = '0, trig_data_hi = '0, trig_data_lo = '0;
  logic        mem_valid, mem_write, busy;
  logic        mem_ready = 1'b0;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_rdata;
  logic [63:0] mem_wdata;

  blkmov_engine i_blkmov_engine (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_ready(trig_ready),
    .trig_space(trig_space), .trig_addr(trig_addr), .trig_data_hi(trig_data_hi),
    .trig_data_lo(trig_data_lo), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model: read data is a fixed function of the address.
  function automatic logic [31:0] rd_fn(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, ~a[31:16]};
  endfunction
  assign mem_rdata = rd_fn(mem_addr);

  int          stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] lg_addr [16];
  logic        lg_wr   [16];
  logic [1:0]  lg_sz   [16];
  logic [63:0] lg_wd   [16];
  int          log_n = 0;

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (stall_mode)
      0: mem_ready = 1'b1;
      1: mem_ready = lfsr[0];
      default: mem_ready = 1'b0;
    endcase
    #1;
    if (mem_valid && mem_ready) begin
      if (log_n < 16) begin
        lg_addr[log_n] = mem_addr;
        lg_wr[log_n]   = mem_write;
        lg_sz[log_n]   = mem_size;
        lg_wd[log_n]   = mem_wdata;
      end
      log_n++;
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // {space, addr, op_hi, op_lo, stall}
  localparam logic [104:0] VEC [6] = '{
    {8'h17, 32'h0000_1003, 32'h0000_2002, 32'h0000_0000, 1'b0},
    {8'h1F, 32'h0000_4005, 32'hDEAD_BEEF, 32'h0123_4567, 1'b0},
    {8'h17, 32'h8000_0000, 32'h0000_0101, 32'hFFFF_FFFF, 1'b1},
    {8'h1F, 32'hFFFF_FFE7, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b1},
    {8'h17, 32'hFFFF_FFF2, 32'h0000_0FFD, 32'h1234_5678, 1'b1},
    {8'h1F, 32'h0000_0008, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0}
  };

  task automatic send(input logic [7:0] sp, input logic [31:0] a, hi, lo,
                      input bit expect_busy);
    @(negedge clk); #3;
    chk(trig_ready == 1'b1, "R6 ready when idle", 64'(trig_ready), 64'd1);
    trig_valid = 1'b1; trig_space = sp; trig_addr = a;
    trig_data_hi = hi; trig_data_lo = lo;
    @(posedge clk); #1;
    trig_valid = 1'b0;
    chk(busy == expect_busy, expect_busy ? "R6 busy rises" : "R7 busy stays low",
        64'(busy), 64'(expect_busy));
  endtask

  task automatic wait_beats(input int n);
    int t = 0;
    while (log_n < n && t < 400) begin
      @(negedge clk); #2; t++;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #3;
    chk(busy == 1'b0, "R1 busy after reset", 64'(busy), 64'd0);
    chk(mem_valid == 1'b0, "R1 mem_valid after reset", 64'(mem_valid), 64'd0);
    chk(trig_ready == 1'b1, "R1 trig_ready after reset", 64'(trig_ready), 64'd1);

    // Vector table walk: R2, R3, R4, R6, R8
    for (int v = 0; v < 6; v++) begin
      logic [7:0]  sp;
      logic [31:0] a, hi, lo, src, dst;
      bit          is_copy;
      int          nexp;
      sp = VEC[v][104:97]; a = VEC[v][96:65]; hi = VEC[v][64:33]; lo = VEC[v][32:1];
      stall_mode = VEC[v][0] ? 1 : 0;
      is_copy = (sp == 8'h17);
      nexp = is_copy ? 16 : 4;
      log_n = 0;
      send(sp, a, hi, lo, 1'b1);
      wait_beats(nexp);
      chk(log_n == nexp, is_copy ? "R3 copy beat count" : "R4 fill beat count",
          64'(log_n), 64'(nexp));
      chk(busy == 1'b1, "R6 busy held to last write", 64'(busy), 64'd1);
      @(negedge clk); #2;
      chk(busy == 1'b0, "R6 busy falls after last write", 64'(busy), 64'd0);
      chk(log_n == nexp, "R8 no beat after done", 64'(log_n), 64'(nexp));
      if (is_copy) begin
        src = hi & ~32'h3; dst = a & ~32'h3;
        for (int i = 0; i < 8; i++) begin
          logic [31:0] sa, da;
          sa = src + 32'(4 * i); da = dst + 32'(4 * i);
          chk(lg_addr[2*i] == sa && lg_wr[2*i] == 1'b0 && lg_sz[2*i] == 2'd2,
              "R2 copy read beat", {lg_addr[2*i], 29'd0, lg_wr[2*i], lg_sz[2*i]},
              {sa, 29'd0, 1'b0, 2'd2});
          chk(lg_addr[2*i+1] == da && lg_wr[2*i+1] == 1'b1 && lg_sz[2*i+1] == 2'd2,
              "R3 copy write beat", {lg_addr[2*i+1], 29'd0, lg_wr[2*i+1], lg_sz[2*i+1]},
              {da, 29'd0, 1'b1, 2'd2});
          chk(lg_wd[2*i+1] == {32'd0, rd_fn(sa)}, "R3 copy write data",
              lg_wd[2*i+1], {32'd0, rd_fn(sa)});
        end
      end else begin
        dst = a & ~32'h7;
        for (int i = 0; i < 4; i++) begin
          logic [31:0] da;
          da = dst + 32'(8 * i);
          chk(lg_addr[i] == da && lg_wr[i] == 1'b1 && lg_sz[i] == 2'd3,
              "R4 fill beat", {lg_addr[i], 29'd0, lg_wr[i], lg_sz[i]},
              {da, 29'd0, 1'b1, 2'd3});
          chk(lg_wd[i] == {hi, lo}, "R4 fill pattern", lg_wd[i], {hi, lo});
        end
      end
    end

    // R7: other space codes are dropped
    stall_mode = 0;
    log_n = 0;
    send(8'h20, 32'h0000_3000, 32'h0000_4000, 32'h0, 1'b0);
    repeat (5) @(negedge clk);
    #2;
    chk(log_n == 0, "R7 no beats for other code", 64'(log_n), 64'd0);
    chk(busy == 1'b0, "R7 still idle", 64'(busy), 64'd0);
    send(8'h16, 32'h0000_3000, 32'h0000_4000, 32'h0, 1'b0);
    repeat (3) @(negedge clk);
    #2;
    chk(log_n == 0 && mem_valid == 1'b0, "R7 no request for 0x16",
        64'(log_n), 64'd0);

    // R5 hold under stall, R6 back-pressure of a waiting trigger
    stall_mode = 2;
    log_n = 0;
    send(8'h17, 32'h0000_0100, 32'h0000_0200, 32'h0, 1'b1);
    @(negedge clk); #3;
    trig_valid = 1'b1; trig_space = 8'h1F; trig_addr = 32'h0000_0900;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #3;
      chk(mem_valid == 1'b1 && mem_addr == 32'h200 && mem_write == 1'b0,
          "R5 beat held while not ready", {mem_valid, mem_write, 30'd0, mem_addr},
          {1'b1, 1'b0, 30'd0, 32'h200});
      chk(trig_ready == 1'b0, "R6 trigger back-pressured", 64'(trig_ready), 64'd0);
    end
    trig_valid = 1'b0;
    chk(log_n == 0, "R5 no progress while stalled", 64'(log_n), 64'd0);
    stall_mode = 0;
    wait_beats(16);
    @(negedge clk); #2;
    chk(lg_addr[0] == 32'h200, "R5 first beat after release", 64'(lg_addr[0]), 64'h200);
    chk(busy == 1'b0, "R6 done after stalled copy", 64'(busy), 64'd0);
    repeat (4) @(negedge clk);
    #2;
    chk(log_n == 16, "R6 back-pressured trigger not taken", 64'(log_n), 64'd16);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule